// File: doc/BRIEF.md
# Serial Service-Bus Request Decoder

This block watches a two-wire serial service bus, a bus clock plus an inverted data line, and decodes the request frames that the master sends to a slave. The bus clock and data come into a faster system clock domain through synchronizers. Each rising edge of the bus clock yields one logical bit. A frame starts with a 1 bit. It carries a slave number, a command prefix of variable length, and the fields that command implies. It ends with a 4-bit check code. The block reports each complete frame as one record on its output.

The block is a passive monitor and never drives the bus. Its result side is a valid-only stream: `req_valid` is high for exactly one system clock and all record fields are valid in that cycle. There is no ready input and no back-pressure, because a monitor cannot stall the bus. The consumer must take each record in the cycle it appears. Decode errors and break events come out on separate single-cycle pulse pins.

A break is a long run of logical 1 bits. It abandons any frame in progress. Decoding resumes after the line returns to logical 0.

Top module: `sbus_req_decoder`

## Requirements
- R1: The data wire is inverted: a low `bus_dat_n` is a logical 1. Exactly one bit is taken per rising edge of `bus_clk`, after synchronization into `clk`.
- R2: A frame begins with a logical 1 start bit. The two slave-number bits follow, with the first received bit being bit 0 of `req_sid`.
- R3: Command prefixes decode as follows, with the value reported on `req_cmd`:
  - 100 → absolute address, 0
  - 101 → relative address, 1
  - 11 → same address, 2
  - 010 → data poll, 3
  - 011 → error poll, 4
  - 001 → interrupt poll, 5
  
  Poll commands go straight to the check code, with `req_addr`=0 and `req_size`=3.
- R4: If 8 command bits arrive without a match, `err_cmd` pulses, no record is produced, and the decoder returns to idle.
- R5: Address commands carry the following fields, in order:
  - a direction bit (1 = read), reported on `req_read`;
  - for relative commands only, a sign bit reported on `req_neg`;
  - an address sent MSB first: `ADDR_W` (21) bits for absolute, 8 bits for relative, 2 bits for same-address.
- R6: The size bit is decoded against the two low received address bits. A size bit of 0 gives byte (`req_size`=0). A size bit of 1 gives 32-bit word (2) when the low bits are 01, and halfword (1) when bit 0 is 0. Any other case pulses `err_size` and returns to idle without a record.
- R7: A read whose low address bits are 11 and whose size bit is 1 is a terminate command. It is reported with `req_cmd`=6, `req_read`=0 and `req_size`=3, and goes directly to the check code.
- R8: Writes carry 8, 16 or 32 data bits, MSB first, on `req_wdata`. Reads carry none, and `req_wdata` is 0 for them.
- R9: The check code is a 4-bit Galois LFSR that starts at zero. For each bit, fb = c[3]^bit and the next value is {c[2], c[1]^fb, c[0]^fb, fb}. It runs over every bit from the start bit up to the received code, and the received code arrives MSB first. `req_crc_ok` reports a match, and `err_crc` pulses with the record when the codes differ.
- R10: `BREAK_LEN` (256) consecutive logical 1 bits pulse `brk_det` once. The frame decoder is then forced out of any frame, and no record or error appears until a logical 0 bit has been seen.
- R11: When a run of more than `BREAK_LEN` logical 1 bits ends, `brk_long` pulses. A run of exactly `BREAK_LEN` ones does not pulse it.
- R12: `req_valid`, `err_cmd`, `err_size`, `err_crc`, `brk_det` and `brk_long` are single-cycle pulses.
- R13: After reset all pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk | input | 1 | Bus clock, asynchronous to `clk` |
| bus_dat_n | input | 1 | Bus data line, electrically inverted |
| req_valid | output | 1 | One-cycle strobe: a full frame was decoded |
| req_sid | output | 2 | Slave number |
| req_cmd | output | 3 | Command code (see R3, R7) |
| req_read | output | 1 | 1 for a read request |
| req_neg | output | 1 | Sign bit of a relative address |
| req_addr | output | ADDR_W | Address as received, right-aligned |
| req_size | output | 2 | 0 byte, 1 halfword, 2 word, 3 none |
| req_wdata | output | DATA_W | Write data, right-aligned |
| req_crc_ok | output | 1 | Received check code matched |
| err_cmd | output | 1 | Pulse: unknown command prefix |
| err_size | output | 1 | Pulse: illegal size and address combination |
| err_crc | output | 1 | Pulse: check code mismatch |
| brk_det | output | 1 | Pulse: break detected |
| brk_long | output | 1 | Pulse: break run was longer than allowed |

## Verification
The embedded properties check, on every cycle, the following:
- bit strobes never come back to back;
- every break pulse leaves the frame decoder in its wait-for-zero state;
- every write record carries a size;
- record and break strobes last one cycle.

Whether prefixes, field lengths, bit orders, size decoding, terminate reinterpretation and the check-code arithmetic match the bus format can only be shown by the bench. It drives whole frames and compares records against values it derives itself. The break scenarios show that frames resume only after a zero, and that the over-length warning is given only for runs beyond the limit.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SID, ST_CMD, ST_DIR, ST_SIGN,
    ST_ADDR, ST_SIZE, ST_WDATA, ST_CRC, ST_HOLD
  } state_e;

  typedef enum logic [2:0] {
    CMD_ABS   = 3'd0,
    CMD_REL   = 3'd1,
    CMD_SAME  = 3'd2,
    CMD_DPOLL = 3'd3,
    CMD_EPOLL = 3'd4,
    CMD_IPOLL = 3'd5,
    CMD_TERM  = 3'd6,
    CMD_NONE  = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_NONE = 2'd3
  } size_e;

  // One step of the x^4+x^2+x+1 Galois register, MSB-first input.
  function automatic logic [3:0] crc4_step(input logic [3:0] c, input logic b);
    logic fb;
    fb = c[3] ^ b;
    return {c[2], c[1] ^ fb, c[0] ^ fb, fb};
  endfunction

endpackage

// File: rtl/sbus_bit_sampler.sv
module sbus_bit_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_clk,
  input  logic bus_dat_n,
  output logic bit_stb,
  output logic bit_val
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] ck_sync;
  logic [TOP:0] dt_sync;
  logic         ck_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_sync <= '0;
      dt_sync <= '1;
      ck_last <= 1'b0;
    end else begin
      ck_sync <= {ck_sync[TOP-1:0], bus_clk};
      dt_sync <= {dt_sync[TOP-1:0], bus_dat_n};
      ck_last <= ck_sync[TOP];
    end
  end

  // Rising bus-clock edge seen in the system domain; wire is inverted.
  assign bit_stb = ck_sync[TOP] & ~ck_last;
  assign bit_val = ~dt_sync[TOP];

  assert_strobe_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb);

endmodule

// File: rtl/sbus_break_det.sv
module sbus_break_det #(
  parameter int BREAK_LEN = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic bit_val,
  output logic brk,
  output logic brk_long
);
  localparam int RUN_W = $clog2(BREAK_LEN + 2);
  localparam logic [RUN_W-1:0] RUN_SAT  = RUN_W'(BREAK_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(BREAK_LEN - 1);
  localparam logic [RUN_W-1:0] RUN_LIM  = RUN_W'(BREAK_LEN);

  logic [RUN_W-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= '0;
      brk      <= 1'b0;
      brk_long <= 1'b0;
    end else begin
      brk      <= 1'b0;
      brk_long <= 1'b0;
      if (bit_stb) begin
        if (bit_val) begin
          if (run != RUN_SAT) run <= run + 1'b1;
          brk <= (run == RUN_LAST);
        end else begin
          brk_long <= (run > RUN_LIM);
          run      <= '0;
        end
      end
    end
  end

  assert_break_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> !brk);

endmodule

// File: rtl/sbus_crc4.sv
module sbus_crc4 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_stb,
  input  logic       bit_val,
  input  logic       crc_en,
  input  logic       crc_seed,
  output logic [3:0] crc
);
  import sbus_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                crc <= '0;
    else if (bit_stb && crc_en) crc <= crc4_step(crc_seed ? 4'd0 : crc, bit_val);
  end

endmodule

// File: rtl/sbus_frame_parser.sv
module sbus_frame_parser #(
  parameter int ADDR_W    = 21,
  parameter int DATA_W    = 32,
  parameter int REL_BITS  = 8,
  parameter int SAME_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic              brk_i,
  input  logic [3:0]        crc_i,
  output logic              crc_en,
  output logic              crc_seed,
  output logic              req_valid,
  output logic [1:0]        req_sid,
  output logic [2:0]        req_cmd,
  output logic              req_read,
  output logic              req_neg,
  output logic [ADDR_W-1:0] req_addr,
  output logic [1:0]        req_size,
  output logic [DATA_W-1:0] req_wdata,
  output logic              req_crc_ok,
  output logic              err_cmd,
  output logic              err_size,
  output logic              err_crc
);
  import sbus_pkg::*;

  localparam int MAXW  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int CNT_W = $clog2(MAXW + 1);

  state_e            state;
  cmd_e              cmd, hit_cmd;
  size_e             size, sz_n;
  logic [CNT_W-1:0]  cnt, cnt_n, alen, dlen;
  logic [6:0]        code;
  logic [7:0]        code_n;
  logic [2:0]        crc_rx;
  logic [1:0]        sid;
  logic              rd, neg, hit, sz_bad, is_term;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;

  assign cnt_n  = cnt + 1'b1;
  assign code_n = {code, bit_val};

  // Prefix match on the bits seen so far.
  always_comb begin
    hit     = 1'b0;
    hit_cmd = CMD_NONE;
    if (cnt_n == CNT_W'(2) && code_n[1:0] == 2'b11) begin
      hit = 1'b1; hit_cmd = CMD_SAME;
    end else if (cnt_n == CNT_W'(3)) begin
      hit = 1'b1;
      case (code_n[2:0])
        3'b100:  hit_cmd = CMD_ABS;
        3'b101:  hit_cmd = CMD_REL;
        3'b010:  hit_cmd = CMD_DPOLL;
        3'b011:  hit_cmd = CMD_EPOLL;
        3'b001:  hit_cmd = CMD_IPOLL;
        default: hit = 1'b0;
      endcase
    end
  end

  always_comb begin
    case (cmd)
      CMD_ABS: alen = CNT_W'(ADDR_W);
      CMD_REL: alen = CNT_W'(REL_BITS);
      default: alen = CNT_W'(SAME_BITS);
    endcase
    case (size)
      SZ_BYTE: dlen = CNT_W'(DATA_W / 4);
      SZ_HALF: dlen = CNT_W'(DATA_W / 2);
      default: dlen = CNT_W'(DATA_W);
    endcase
  end

  // Size bit against the raw low address bits.
  always_comb begin
    sz_n    = SZ_NONE;
    sz_bad  = 1'b0;
    is_term = rd && (addr[1:0] == 2'b11) && bit_val;
    if (!is_term) begin
      if (!bit_val)                sz_n = SZ_BYTE;
      else if (addr[1:0] == 2'b01) sz_n = SZ_WORD;
      else if (!addr[0])           sz_n = SZ_HALF;
      else                         sz_bad = 1'b1;
    end
  end

  assign crc_en   = (state != ST_CRC) && (state != ST_HOLD);
  assign crc_seed = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;  cmd <= CMD_NONE;  size <= SZ_NONE;
      cnt <= '0;  code <= '0;  crc_rx <= '0;  sid <= '0;
      rd <= 1'b0;  neg <= 1'b0;  addr <= '0;  wdata <= '0;
      req_valid <= 1'b0;  req_crc_ok <= 1'b0;
      err_cmd <= 1'b0;  err_size <= 1'b0;  err_crc <= 1'b0;
    end else begin
      req_valid <= 1'b0;
      err_cmd   <= 1'b0;
      err_size  <= 1'b0;
      err_crc   <= 1'b0;
      if (brk_i) begin
        state <= ST_HOLD;
      end else if (bit_stb) begin
        case (state)
          ST_IDLE: if (bit_val) begin
            state <= ST_SID;  cnt <= '0;  sid <= '0;  code <= '0;
            rd <= 1'b0;  neg <= 1'b0;  addr <= '0;  wdata <= '0;
            size <= SZ_NONE;  cmd <= CMD_NONE;
          end
          ST_SID: begin
            sid <= {bit_val, sid[1]};
            if (cnt == CNT_W'(1)) begin state <= ST_CMD; cnt <= '0; end
            else cnt <= cnt_n;
          end
          ST_CMD: begin
            if (hit) begin
              cmd <= hit_cmd;
              cnt <= '0;
              state <= (hit_cmd inside {CMD_ABS, CMD_REL, CMD_SAME}) ? ST_DIR : ST_CRC;
            end else if (cnt_n == CNT_W'(8)) begin
              err_cmd <= 1'b1;
              state   <= ST_IDLE;
            end else begin
              code <= code_n[6:0];
              cnt  <= cnt_n;
            end
          end
          ST_DIR: begin
            rd    <= bit_val;
            cnt   <= '0;
            state <= (cmd == CMD_REL) ? ST_SIGN : ST_ADDR;
          end
          ST_SIGN: begin
            neg   <= bit_val;
            state <= ST_ADDR;
          end
          ST_ADDR: begin
            addr <= {addr[ADDR_W-2:0], bit_val};
            if (cnt_n == alen) begin state <= ST_SIZE; cnt <= '0; end
            else cnt <= cnt_n;
          end
          ST_SIZE: begin
            cnt <= '0;
            if (is_term) begin
              cmd <= CMD_TERM;  rd <= 1'b0;  state <= ST_CRC;
            end else if (sz_bad) begin
              err_size <= 1'b1;  state <= ST_IDLE;
            end else begin
              size  <= sz_n;
              state <= rd ? ST_CRC : ST_WDATA;
            end
          end
          ST_WDATA: begin
            wdata <= {wdata[DATA_W-2:0], bit_val};
            if (cnt_n == dlen) begin state <= ST_CRC; cnt <= '0; end
            else cnt <= cnt_n;
          end
          ST_CRC: begin
            crc_rx <= {crc_rx[1:0], bit_val};
            if (cnt_n == CNT_W'(4)) begin
              req_valid  <= 1'b1;
              req_crc_ok <= ({crc_rx, bit_val} == crc_i);
              err_crc    <= ({crc_rx, bit_val} != crc_i);
              state      <= ST_IDLE;
              cnt        <= '0;
            end else cnt <= cnt_n;
          end
          ST_HOLD: if (!bit_val) state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign req_sid   = sid;
  assign req_cmd   = cmd;
  assign req_read  = rd;
  assign req_neg   = neg;
  assign req_addr  = addr;
  assign req_size  = size;
  assign req_wdata = wdata;

  assert_break_forces_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    brk_i |=> state == ST_HOLD);

  assert_write_has_size_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rd && (cmd inside {CMD_ABS, CMD_REL, CMD_SAME})) |-> size != SZ_NONE);

  assert_record_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);

endmodule

// File: rtl/sbus_req_decoder.sv
module sbus_req_decoder #(
  parameter int ADDR_W      = 21,
  parameter int DATA_W      = 32,
  parameter int BREAK_LEN   = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_clk,
  input  logic              bus_dat_n,
  output logic              req_valid,
  output logic [1:0]        req_sid,
  output logic [2:0]        req_cmd,
  output logic              req_read,
  output logic              req_neg,
  output logic [ADDR_W-1:0] req_addr,
  output logic [1:0]        req_size,
  output logic [DATA_W-1:0] req_wdata,
  output logic              req_crc_ok,
  output logic              err_cmd,
  output logic              err_size,
  output logic              err_crc,
  output logic              brk_det,
  output logic              brk_long
);
  logic       bit_stb, bit_val, crc_en, crc_seed;
  logic [3:0] crc;

  sbus_bit_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_dat_n(bus_dat_n),
    .bit_stb(bit_stb), .bit_val(bit_val)
  );

  sbus_break_det #(.BREAK_LEN(BREAK_LEN)) u_break (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
    .brk(brk_det), .brk_long(brk_long)
  );

  sbus_crc4 u_crc (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
    .crc_en(crc_en), .crc_seed(crc_seed), .crc(crc)
  );

  sbus_frame_parser #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_parser (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
    .brk_i(brk_det), .crc_i(crc), .crc_en(crc_en), .crc_seed(crc_seed),
    .req_valid(req_valid), .req_sid(req_sid), .req_cmd(req_cmd),
    .req_read(req_read), .req_neg(req_neg), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata), .req_crc_ok(req_crc_ok),
    .err_cmd(err_cmd), .err_size(err_size), .err_crc(err_crc)
  );

endmodule

// File: tb/sbus_req_decoder_test.sv
module sbus_req_decoder_test;
  typedef logic [64:0] rec_t;

  logic        clk = 1'b0;
  logic        rst_n, bus_clk, bus_dat_n;
  logic        req_valid, req_read, req_neg, req_crc_ok;
  logic [1:0]  req_sid, req_size;
  logic [2:0]  req_cmd;
  logic [20:0] req_addr;
  logic [31:0] req_wdata;
  logic        err_cmd, err_size, err_crc, brk_det, brk_long;

  int   checks = 0, fails = 0, ev_total = 0, brk_cnt = 0, long_cnt = 0;
  bit   sb_off = 1'b0, prev_rv = 1'b0;
  bit   fb[$];
  rec_t q[$];

  always #5 clk = ~clk;

  sbus_req_decoder uut (
    .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_dat_n(bus_dat_n),
    .req_valid(req_valid), .req_sid(req_sid), .req_cmd(req_cmd),
    .req_read(req_read), .req_neg(req_neg), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata), .req_crc_ok(req_crc_ok),
    .err_cmd(err_cmd), .err_size(err_size), .err_crc(err_crc),
    .brk_det(brk_det), .brk_long(brk_long)
  );

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s", msg); end
  endtask

  function automatic rec_t mk(input logic [1:0] kind, input logic [1:0] sid,
      input logic [2:0] cmd, input logic rd, input logic neg, input logic [20:0] a,
      input logic [1:0] sz, input logic [31:0] wd, input logic ok);
    return {kind, sid, cmd, rd, neg, a, sz, wd, ok};
  endfunction

  task automatic send_bit(input bit b);
    bus_dat_n = ~b;
    #40 bus_clk = 1'b1;
    #40 bus_clk = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0);
  endtask

  task automatic put(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) fb.push_back(v[i]);
  endtask

  task automatic head(input logic [1:0] sid);
    fb.delete();
    put(1, 1); put(sid[0], 1); put(sid[1], 1);
  endtask

  task automatic send_fb();
    foreach (fb[i]) send_bit(fb[i]);
    fb.delete();
    idle(4);
  endtask

  // Appends the check code (R9), optionally corrupted, then sends.
  task automatic tx(input bit corrupt);
    logic [3:0] c = 4'd0;
    logic       f;
    foreach (fb[i]) begin
      f = c[3] ^ fb[i];
      c = {c[2], c[1] ^ f, c[0] ^ f, f};
    end
    put({28'd0, c ^ {3'b000, corrupt}}, 4);
    send_fb();
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_rv) chk(!req_valid, $sformatf("R12 req_valid width actual=%0b expected=0", req_valid));
      prev_rv = req_valid;
      if (brk_det) brk_cnt++;
      if (brk_long) long_cnt++;
      if (req_valid || err_cmd || err_size) begin
        ev_total++;
        if (!sb_off) begin
          rec_t act, exp;
          if (req_valid) begin
            act = mk(2'd0, req_sid, req_cmd, req_read, req_neg, req_addr, req_size, req_wdata, req_crc_ok);
            chk(err_crc == !req_crc_ok, $sformatf("R9 err_crc actual=%0b expected=%0b", err_crc, !req_crc_ok));
          end else act = mk(err_cmd ? 2'd1 : 2'd2, 0, 0, 0, 0, 0, 0, 0, 0);
          if (q.size() == 0) chk(1'b0, $sformatf("R2 unexpected record actual=%h expected=none", act));
          else begin
            exp = q.pop_front();
            chk(act === exp, $sformatf("R3/R5 record actual=%h expected=%h", act, exp));
          end
        end
      end
    end
  end

  initial begin
    #1_000_000;
    chk(1'b0, "R13 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int snap;
    rst_n = 1'b0; bus_clk = 1'b0; bus_dat_n = 1'b1;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({req_valid, err_cmd, err_size, err_crc, brk_det, brk_long} == 6'd0,
        "R13 reset pulses actual=nonzero expected=0");
    idle(4);

    // R1 R2 R5 R6 R8: absolute write, word (low bits 01)
    head(2'b01); put(3'b100, 3); put(0, 1); put(21'h12345, 21); put(1, 1); put(32'hDEADBEEF, 32);
    q.push_back(mk(0, 2'b01, 0, 0, 0, 21'h12345, 2, 32'hDEADBEEF, 1)); tx(0);
    // R6 R8: absolute write, halfword (low bit 0)
    head(2'b10); put(3'b100, 3); put(0, 1); put(21'h0ABCDE, 21); put(1, 1); put(16'hC3A5, 16);
    q.push_back(mk(0, 2'b10, 0, 0, 0, 21'h0ABCDE, 1, 32'h0000C3A5, 1)); tx(0);
    // R6 R8: byte write with low bits 11
    head(2'b11); put(3'b100, 3); put(0, 1); put(21'h1FFFFF, 21); put(0, 1); put(8'h5A, 8);
    q.push_back(mk(0, 2'b11, 0, 0, 0, 21'h1FFFFF, 0, 32'h5A, 1)); tx(0);
    // R5: relative write, negative sign, byte
    head(2'b10); put(3'b101, 3); put(0, 1); put(1, 1); put(8'h5C, 8); put(0, 1); put(8'hA7, 8);
    q.push_back(mk(0, 2'b10, 1, 0, 1, 21'h5C, 0, 32'hA7, 1)); tx(0);
    // R5 R6: same-address read, word
    head(2'b00); put(2'b11, 2); put(1, 1); put(2'b01, 2); put(1, 1);
    q.push_back(mk(0, 2'b00, 2, 1, 0, 21'h1, 2, 0, 1)); tx(0);
    // R7: read with low bits 11 and size 1 is terminate
    head(2'b01); put(2'b11, 2); put(1, 1); put(2'b11, 2); put(1, 1);
    q.push_back(mk(0, 2'b01, 6, 0, 0, 21'h3, 3, 0, 1)); tx(0);
    // R3: the three polls
    head(2'b11); put(3'b010, 3); q.push_back(mk(0, 2'b11, 3, 0, 0, 0, 3, 0, 1)); tx(0);
    head(2'b00); put(3'b011, 3); q.push_back(mk(0, 2'b00, 4, 0, 0, 0, 3, 0, 1)); tx(0);
    head(2'b10); put(3'b001, 3); q.push_back(mk(0, 2'b10, 5, 0, 0, 0, 3, 0, 1)); tx(0);
    // R4: eight zero command bits
    head(2'b01); put(8'h00, 8); q.push_back(mk(1, 0, 0, 0, 0, 0, 0, 0, 0)); send_fb();
    // R6: write, size 1, low bits 11 -> size error
    head(2'b01); put(2'b11, 2); put(0, 1); put(2'b11, 2); put(1, 1);
    q.push_back(mk(2, 0, 0, 0, 0, 0, 0, 0, 0)); send_fb();
    // R9: corrupted check code
    head(2'b01); put(3'b010, 3); q.push_back(mk(0, 2'b01, 3, 0, 0, 0, 3, 0, 0)); tx(1);
    chk(q.size() == 0, $sformatf("R9 pending records actual=%0d expected=0", q.size()));

    // R10: exact-length break inside a frame
    sb_off = 1'b1;
    head(2'b01); send_fb();
    fb.delete(); put(1, 1); put(1, 1); put(0, 1); foreach (fb[i]) send_bit(fb[i]); fb.delete();
    for (int i = 0; i < 256; i++) send_bit(1'b1);
    repeat (4) @(negedge clk);
    snap = ev_total;
    idle(6);
    chk(brk_cnt == 1, $sformatf("R10 break count actual=%0d expected=1", brk_cnt));
    chk(long_cnt == 0, $sformatf("R11 long count actual=%0d expected=0", long_cnt));
    chk(ev_total == snap, $sformatf("R10 events after break actual=%0d expected=%0d", ev_total, snap));
    sb_off = 1'b0;
    head(2'b10); put(3'b100, 3); put(1, 1); put(21'h000010, 21); put(0, 1);
    q.push_back(mk(0, 2'b10, 0, 1, 0, 21'h10, 0, 0, 1)); tx(0);

    // R10 R11: over-length break, no frames while ones continue
    sb_off = 1'b1;
    for (int i = 0; i < 256; i++) send_bit(1'b1);
    repeat (4) @(negedge clk);
    snap = ev_total;
    for (int i = 0; i < 44; i++) send_bit(1'b1);
    idle(6);
    chk(ev_total == snap, $sformatf("R10 events during long break actual=%0d expected=%0d", ev_total, snap));
    chk(brk_cnt == 2, $sformatf("R10 break count actual=%0d expected=2", brk_cnt));
    chk(long_cnt == 1, $sformatf("R11 long count actual=%0d expected=1", long_cnt));
    sb_off = 1'b0;
    head(2'b11); put(3'b011, 3); q.push_back(mk(0, 2'b11, 4, 0, 0, 0, 3, 0, 1)); tx(0);

    repeat (10) @(negedge clk);
    chk(q.size() == 0, $sformatf("R2 pending records actual=%0d expected=0", q.size()));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule